// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block drives one port of up to 32 bidirectional pads from a plain register bus. It holds three pieces of state: an output latch, a direction word and a mask word. A pad is driven only while its direction bit is 1, and the value it drives is taken from the latch. Input levels pass through a two-flop sampler before any read path uses them.

Software can reach the same state through several views. One view gives each pin its own byte address. Another moves the whole port in a single raw word. A third filters reads and writes through the mask. The last set of views are write-one-to-act strobes that set, clear or invert chosen bits of the latch or of the direction word without a read-modify-write.

Every bus write lands on the clock edge at which the write strobe is sampled. Read data comes from a register and is valid in the cycle after the read strobe. It holds that value until the next read.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, the output latch, direction word and mask word are all zero. So `pin_out` = 0, `pin_oe` = 0 and `bus_rdata` = 0.
- R2: At byte addresses 0 to NPINS-1, address i stands for pin i. A write sets latch bit i to 1 when `bus_wdata[7:0]` is nonzero and to 0 when it is zero. A read returns the sampled level of pin i in bit 0, with all other bits 0.
- R3: Address 0x2000 holds the direction word and can be written and read. `pin_oe` equals that word, with 1 meaning output.
- R4: Address 0x2080 holds the mask word and can be written and read. A 0 bit lets that pin through the masked view, and a 1 bit blocks it.
- R5: Address 0x2100 is the raw port. A write loads the whole latch, ignoring the mask. A read returns the sampled level of every pin, ignoring the mask.
- R6: Address 0x2180 is the masked port. A write changes only latch bits whose mask bit is 0. A read returns the sampled pin levels with every blocked bit forced to 0.
- R7: A write to 0x2200 sets the latch bits that are 1 in the data and leaves the other bits alone. A read of 0x2200 returns the latch itself, not the pin levels.
- R8: A write to 0x2280 clears the latch bits that are 1 in the data. A write to 0x2300 inverts them. Bits that are 0 in the data are unchanged, and reads of both addresses return 0.
- R9: Writes to 0x2380, 0x2400 and 0x2480 set, clear and invert the direction bits that are 1 in the data. Reads of these three addresses return 0.
- R10: A change on `pin_in` that is stable ahead of edge E0 first shows up in a read whose strobe is sampled at edge E0+2. Reads sampled at E0 and E0+1 still return the old level.
- R11: `bus_rdata` updates one cycle after `bus_re` is sampled and holds its value while `bus_re` is low. When a write and a read hit the same address in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Pad output values (the latch) |
| pin_oe | output | NPINS | Pad output enables (the direction word) |

## Verification
A write and a read can share one cycle and one address. The bench provokes this on the set, mask and raw addresses by raising both strobes together. The scoreboard takes its expected read value from the model before it applies that write. It then checks `pin_out` or the next read to confirm that the write still landed. Another overlap is a pad level change arriving while reads are in flight. Reads issued back to back straight after the change must return the old level twice and the new level on the third read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Which register view an address selects
  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_BYTE,
    ACC_DIR,
    ACC_MASK,
    ACC_RAW,
    ACC_MSKD,
    ACC_OSET,
    ACC_OCLR,
    ACC_OTGL,
    ACC_DSET,
    ACC_DCLR,
    ACC_DTGL
  } acc_kind_e;

  // Word offsets of the port-wide registers
  localparam logic [15:0] OFS_DIR  = 16'h2000;
  localparam logic [15:0] OFS_MASK = 16'h2080;
  localparam logic [15:0] OFS_RAW  = 16'h2100;
  localparam logic [15:0] OFS_MSKD = 16'h2180;
  localparam logic [15:0] OFS_OSET = 16'h2200;
  localparam logic [15:0] OFS_OCLR = 16'h2280;
  localparam logic [15:0] OFS_OTGL = 16'h2300;
  localparam logic [15:0] OFS_DSET = 16'h2380;
  localparam logic [15:0] OFS_DCLR = 16'h2400;
  localparam logic [15:0] OFS_DTGL = 16'h2480;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int NPINS  = 32,
  parameter int PIN_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [PIN_W-1:0]  pin_idx
);

  // Word registers ignore the two low address bits
  function automatic logic word_hit(input logic [ADDR_W-1:0] a, input logic [15:0] ofs);
    return a[ADDR_W-1:2] == ofs[ADDR_W-1:2];
  endfunction

  logic byte_hit;

  assign byte_hit = 32'(addr) < NPINS;
  assign pin_idx  = addr[PIN_W-1:0];

  always_comb begin
    kind = ACC_NONE;
    if (byte_hit)                     kind = ACC_BYTE;
    else if (word_hit(addr, OFS_DIR))  kind = ACC_DIR;
    else if (word_hit(addr, OFS_MASK)) kind = ACC_MASK;
    else if (word_hit(addr, OFS_RAW))  kind = ACC_RAW;
    else if (word_hit(addr, OFS_MSKD)) kind = ACC_MSKD;
    else if (word_hit(addr, OFS_OSET)) kind = ACC_OSET;
    else if (word_hit(addr, OFS_OCLR)) kind = ACC_OCLR;
    else if (word_hit(addr, OFS_OTGL)) kind = ACC_OTGL;
    else if (word_hit(addr, OFS_DSET)) kind = ACC_DSET;
    else if (word_hit(addr, OFS_DCLR)) kind = ACC_DCLR;
    else if (word_hit(addr, OFS_DTGL)) kind = ACC_DTGL;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);

  logic [NPINS-1:0] stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < DEPTH; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[DEPTH-1];

endmodule

// File: rtl/gpio_state_regs.sv
module gpio_state_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  acc_kind_e        kind,
  input  logic [PIN_W-1:0] pin_idx,
  input  logic [NPINS-1:0] wdata,
  input  logic             wbyte_nz,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] mask_q
);

  logic [NPINS-1:0] out_nx;
  logic [NPINS-1:0] dir_nx;
  logic [NPINS-1:0] mask_nx;

  // One slice per pin: each bit works out its own next latch and direction value
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic o_n;
    logic d_n;

    always_comb begin
      o_n = out_q[i];
      d_n = dir_q[i];
      if (we) begin
        case (kind)
          ACC_BYTE: if (pin_idx == PIN_W'(i)) o_n = wbyte_nz;
          ACC_RAW:  o_n = wdata[i];
          ACC_MSKD: if (!mask_q[i]) o_n = wdata[i];
          ACC_OSET: if (wdata[i]) o_n = 1'b1;
          ACC_OCLR: if (wdata[i]) o_n = 1'b0;
          ACC_OTGL: if (wdata[i]) o_n = ~out_q[i];
          ACC_DIR:  d_n = wdata[i];
          ACC_DSET: if (wdata[i]) d_n = 1'b1;
          ACC_DCLR: if (wdata[i]) d_n = 1'b0;
          ACC_DTGL: if (wdata[i]) d_n = ~dir_q[i];
          default: ;
        endcase
      end
    end

    assign out_nx[i] = o_n;
    assign dir_nx[i] = d_n;
  end

  assign mask_nx = (we && kind == ACC_MASK) ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      out_q  <= out_nx;
      dir_q  <= dir_nx;
      mask_q <= mask_nx;
    end
  end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int PIN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  acc_kind_e         kind,
  input  logic [PIN_W-1:0]  pin_idx,
  input  logic [NPINS-1:0]  pins,
  input  logic [NPINS-1:0]  out_q,
  input  logic [NPINS-1:0]  dir_q,
  input  logic [NPINS-1:0]  mask_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic [NPINS-1:0]  sel_word;
  logic [DATA_W-1:0] rd_nx;

  always_comb begin
    sel_word = '0;
    case (kind)
      ACC_DIR:  sel_word = dir_q;
      ACC_MASK: sel_word = mask_q;
      ACC_RAW:  sel_word = pins;
      ACC_MSKD: sel_word = pins & ~mask_q;
      ACC_OSET: sel_word = out_q;
      default:  sel_word = '0;
    endcase
  end

  // The byte view returns a single bit in position 0; write-only views return 0
  assign rd_nx = (kind == ACC_BYTE) ? DATA_W'(pins[pin_idx]) : DATA_W'(sel_word);

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= rd_nx;
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  acc_kind_e        kind;
  logic [PIN_W-1:0] pin_idx;
  logic [NPINS-1:0] pins_s;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] mask_q;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NPINS(NPINS), .PIN_W(PIN_W)) dec_i (
    .addr    (bus_addr),
    .kind    (kind),
    .pin_idx (pin_idx)
  );

  gpio_in_sync #(.NPINS(NPINS), .DEPTH(2)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pins_s)
  );

  gpio_state_regs #(.NPINS(NPINS), .PIN_W(PIN_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .we       (bus_we),
    .kind     (kind),
    .pin_idx  (pin_idx),
    .wdata    (bus_wdata[NPINS-1:0]),
    .wbyte_nz (|bus_wdata[7:0]),
    .out_q    (out_q),
    .dir_q    (dir_q),
    .mask_q   (mask_q)
  );

  gpio_read_mux #(.NPINS(NPINS), .DATA_W(DATA_W), .PIN_W(PIN_W)) rmux_i (
    .clk     (clk),
    .rst     (rst),
    .re      (bus_re),
    .kind    (kind),
    .pin_idx (pin_idx),
    .pins    (pins_s),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .mask_q  (mask_q),
    .rdata_q (bus_rdata)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  mask_q
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

  assert_oe_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(pin_oe));

  assert_out_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(pin_out));

  assert_masked_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_MSKD[ADDR_W-1:0])
      |=> ((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0);

  assert_clr_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == OFS_OCLR[ADDR_W-1:0]) |=> bus_rdata == '0);

  assert_dirset_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_DSET[ADDR_W-1:0])
      |=> (pin_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .mask_q    (mask_q)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int AW = 14;

  localparam logic [AW-1:0] A_DIR  = 14'h2000;
  localparam logic [AW-1:0] A_MASK = 14'h2080;
  localparam logic [AW-1:0] A_RAW  = 14'h2100;
  localparam logic [AW-1:0] A_MSKD = 14'h2180;
  localparam logic [AW-1:0] A_OSET = 14'h2200;
  localparam logic [AW-1:0] A_OCLR = 14'h2280;
  localparam logic [AW-1:0] A_OTGL = 14'h2300;
  localparam logic [AW-1:0] A_DSET = 14'h2380;
  localparam logic [AW-1:0] A_DCLR = 14'h2400;
  localparam logic [AW-1:0] A_DTGL = 14'h2480;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic          bus_we;
  logic          bus_re;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_exp;
  logic        re_d;

  // Reference model kept from the requirements
  logic [31:0] m_out, m_dir, m_mask, m_pin;

  gpio_port_ctrl #(.NPINS(NP), .ADDR_W(AW), .DATA_W(32)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] predict(logic [AW-1:0] a);
    if (a < 14'(NP)) return {31'b0, m_pin[a[4:0]]};
    case (a)
      A_DIR:   return m_dir;
      A_MASK:  return m_mask;
      A_RAW:   return m_pin;
      A_MSKD:  return m_pin & ~m_mask;
      A_OSET:  return m_out;
      default: return 32'h0;
    endcase
  endfunction

  task automatic apply(logic [AW-1:0] a, logic [31:0] wd);
    if (a < 14'(NP)) m_out[a[4:0]] = |wd[7:0];
    else case (a)
      A_DIR:  m_dir  = wd;
      A_MASK: m_mask = wd;
      A_RAW:  m_out  = wd;
      A_MSKD: m_out  = (m_out & m_mask) | (wd & ~m_mask);
      A_OSET: m_out  = m_out | wd;
      A_OCLR: m_out  = m_out & ~wd;
      A_OTGL: m_out  = m_out ^ wd;
      A_DSET: m_dir  = m_dir | wd;
      A_DCLR: m_dir  = m_dir & ~wd;
      A_DTGL: m_dir  = m_dir ^ wd;
      default: ;
    endcase
  endtask

  task automatic push(logic [31:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_exp = e;
  endtask

  // Driver: one bus cycle, called at a falling edge; the expected read is taken before the write
  task automatic op(logic [AW-1:0] a, logic [31:0] wd, bit w, bit r, string tag);
    if (r) push(predict(a), tag);
    if (w) apply(a, wd);
    bus_addr  = a;
    bus_wdata = wd;
    bus_we    = w;
    bus_re    = r;
    @(negedge clk);
    bus_we = 1'b0;
    bus_re = 1'b0;
  endtask

  task automatic rd_exp(logic [AW-1:0] a, logic [31:0] e, string tag);
    push(e, tag);
    bus_addr = a;
    bus_re   = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Monitor: pop one expectation for every read strobe sampled at the previous edge
  always @(posedge clk) re_d <= rst ? 1'b0 : bus_re;

  always @(negedge clk) begin
    if (!rst && re_d) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R11: unexpected read data actual %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    pin_in = '0;
    m_out = '0; m_dir = '0; m_mask = '0; m_pin = '0;
    last_exp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    op(A_DIR, 0, 0, 1, "R1 dir read");
    op(A_MASK, 0, 0, 1, "R1 mask read");

    // R3: direction word
    op(A_DIR, 32'hF0F0_00FF, 1, 0, "");
    check("R3 pin_oe", pin_oe, m_dir);
    op(A_DIR, 0, 0, 1, "R3 dir read");

    // R4: mask word
    op(A_MASK, 32'h0000_FFFF, 1, 0, "");
    op(A_MASK, 0, 0, 1, "R4 mask read");

    pin_in = 32'hA5C3_9617;
    m_pin  = pin_in;
    idle(3);

    // R5: raw port ignores the mask
    op(A_RAW, 32'h1234_5678, 1, 0, "");
    check("R5 raw write", pin_out, 32'h1234_5678);
    op(A_RAW, 0, 0, 1, "R5 raw read");

    // R6: masked port
    op(A_MSKD, 32'hFFFF_FFFF, 1, 0, "");
    check("R6 masked write", pin_out, 32'hFFFF_5678);
    op(A_MSKD, 0, 0, 1, "R6 masked read");

    // R2: byte view, nonzero data in bits other than 0 counts as true
    op(14'd3, 32'h0, 1, 0, "");
    op(14'd8, 32'h40, 1, 0, "");
    op(14'd31, 32'h1, 1, 0, "");
    check("R2 byte writes", pin_out, m_out);
    op(14'd0, 0, 0, 1, "R2 byte read pin0");
    op(14'd3, 0, 0, 1, "R2 byte read pin3");
    op(14'd31, 0, 0, 1, "R2 byte read pin31");

    // R7: set strobe and latch readback
    op(A_OSET, 32'h0000_0F00, 1, 0, "");
    check("R7 set", pin_out, m_out);
    op(A_OSET, 0, 0, 1, "R7 latch read");

    // R8: clear and toggle strobes, write-only reads
    op(A_OCLR, 32'hF000_0001, 1, 0, "");
    check("R8 clear", pin_out, m_out);
    op(A_OTGL, 32'h00FF_00FF, 1, 0, "");
    check("R8 toggle", pin_out, m_out);
    op(A_OCLR, 0, 0, 1, "R8 clr read");
    op(A_OTGL, 0, 0, 1, "R8 tgl read");

    // R9: direction strobes
    op(A_DSET, 32'h0F00_0000, 1, 0, "");
    op(A_DCLR, 32'h0000_00F0, 1, 0, "");
    op(A_DTGL, 32'hFFFF_0000, 1, 0, "");
    check("R9 dir strobes", pin_oe, m_dir);
    op(A_DSET, 0, 0, 1, "R9 dset read");
    op(A_DTGL, 0, 0, 1, "R9 dtgl read");
    op(A_DIR, 0, 0, 1, "R9 dir read");

    // R11: write and read in the same cycle return the old value
    op(A_OSET, 32'hFFFF_FFFF, 1, 1, "R11 set+read");
    check("R11 set landed", pin_out, 32'hFFFF_FFFF);
    op(A_MASK, 32'hFF00_FF00, 1, 1, "R11 mask+read");
    op(A_MASK, 0, 0, 1, "R11 mask after");
    op(A_RAW, 32'h0000_0000, 1, 1, "R11 raw+read");
    check("R11 raw landed", pin_out, 32'h0);
    idle(3);
    check("R11 rdata hold", bus_rdata, last_exp);

    // R10: two-flop sampling latency
    pin_in = 32'h5A5A_0F0F;
    rd_exp(A_RAW, 32'hA5C3_9617, "R10 edge0 old");
    rd_exp(A_RAW, 32'hA5C3_9617, "R10 edge1 old");
    rd_exp(A_RAW, 32'h5A5A_0F0F, "R10 edge2 new");
    m_pin = pin_in;
    op(14'd1, 0, 0, 1, "R10 byte read pin1");

    idle(3);
    check("R11 all reads answered", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule